// File: doc/BRIEF.md
# Prioritised Bus Cycle Controller

This block shares one bus among three requesters: a DMA channel, CPU operand data accesses and CPU instruction fetches. When the bus is idle it picks one requester by fixed priority and grants it a single bus cycle. The length of that cycle depends on the address region it targets. A held grant is never taken away. Arbitration takes place again only in the idle clock that follows the done pulse.

The two top address bits select the region. Internal RAM accesses finish in one clock. The exception is an instruction fetch from internal RAM that meets a competing request in its first clock: that fetch is stretched to two clocks. External memory and external I/O cycles have a fixed minimum length. Programmable wait states are added on top of that minimum, so software cannot shorten a cycle below it. An instruction fetch aimed at the peripheral I/O area never reaches the bus: it completes in one clock and returns a NOP word. Requesters hold their request level until they see done, and they read the returned data in the done clock.

Top module: `bus_cycle_arbiter`

## Requirements
- R1: When the bus is idle and requests are present, the grant appears in the next clock on exactly one bit of `gnt`: bit 2 (DMA) beats bit 1 (operand data), and bit 1 beats bit 0 (fetch).
- R2: A granted cycle keeps the same `gnt` value until its done clock, even if a higher-priority request arrives. In the clock after done, `gnt` is 0. Any next grant comes one clock later.
- R3: The region is decoded from the top two address bits: 00 internal RAM, 01 external memory, 10 external I/O, 11 peripheral I/O.
- R4: An access to internal RAM by any requester raises `done` in its first granted clock (length 1), except in the case described in R5.
- R5: If `reqDma` or `reqData` is high during the first granted clock of a fetch from internal RAM, that fetch raises `done` in its second clock instead.
- R6: An external memory cycle lasts 2 + `extMemWait` clocks, so it is never shorter than 2.
- R7: An external I/O cycle lasts 3 + `extIoWait` clocks, so it is never shorter than 3.
- R8: A fetch from peripheral I/O lasts 1 clock, keeps `busValid` low, and returns `rdData` = 0x00000000 (the NOP word). A DMA or data access to peripheral I/O lasts 1 clock with `busValid` high.
- R9: During a granted bus access, `busAddr` equals the winner's address and `busValid` is high. `waitCnt` starts at length−1 and falls by one each clock. In the done clock, `rdData` equals `busRdData`.
- R10: While reset is asserted and right after it, `gnt`, `done` and `busValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqDma | input | 1 | DMA request, level held until done |
| reqData | input | 1 | CPU operand request, level held until done |
| reqFetch | input | 1 | CPU fetch request, level held until done |
| addrDma | input | AW | DMA address |
| addrData | input | AW | Operand address |
| addrFetch | input | AW | Fetch address |
| extMemWait | input | WW | Extra wait clocks for external memory |
| extIoWait | input | WW | Extra wait clocks for external I/O |
| busRdData | input | DW | Read data returned from the bus |
| gnt | output | 3 | One-hot grant: [2] DMA, [1] data, [0] fetch |
| busAddr | output | AW | Address of the current cycle |
| busValid | output | 1 | A real bus access is in progress |
| waitCnt | output | WW+2 | Clocks remaining after the current one |
| done | output | 1 | Last clock of the granted cycle |
| rdData | output | DW | Read data, valid with done |

## Verification
The assertions assume that each requester keeps its request and address steady from the moment it asks until the clock after its done pulse. They also assume the wait-state inputs do not change while a cycle is running. They assume reset is held for at least one edge before the first request. The bench drives all inputs on falling edges and changes a requester's signals only before its grant or in its done clock. It holds the wait fields constant for the whole of each access. The only mid-cycle change is a new request from a different requester, which is how the contention and no-preemption cases are exercised.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic [1:0] {
    RG_RAM  = 2'b00,
    RG_XMEM = 2'b01,
    RG_XIO  = 2'b10,
    RG_PERI = 2'b11
  } region_e;

  // bit 2 dma, bit 1 operand data, bit 0 fetch
  typedef struct packed {
    logic       load;
    logic [2:0] pick;
    logic       step;
  } strobe_t;
endpackage

// File: rtl/bca_ctrl.sv
module bca_ctrl
  import bca_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] req,
  input  logic       cntZero,
  input  logic       ramFetch,
  output strobe_t    strb,
  output logic [2:0] gnt,
  output logic       done
);
  logic busy;
  logic first;
  logic stretch;

  // fixed priority: dma over data over fetch (R1)
  always_comb begin
    strb.pick = 3'b000;
    if (req[2])      strb.pick = 3'b100;
    else if (req[1]) strb.pick = 3'b010;
    else if (req[0]) strb.pick = 3'b001;
  end

  always_comb begin
    strb.load = !busy && (|req);
    stretch   = busy && first && ramFetch && (req[2] || req[1]);
    done      = busy && cntZero && !stretch;
    strb.step = busy && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      first <= 1'b0;
      gnt   <= 3'b000;
    end else if (strb.load) begin
      busy  <= 1'b1;
      first <= 1'b1;
      gnt   <= strb.pick;
    end else if (done) begin
      busy  <= 1'b0;
      first <= 1'b0;
      gnt   <= 3'b000;
    end else if (busy) begin
      first <= 1'b0;
    end
  end
endmodule

// File: rtl/bca_datapath.sv
module bca_datapath
  import bca_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int WW = 3,
  parameter int XMEM_MIN = 2,
  parameter int XIO_MIN = 3,
  parameter logic [DW-1:0] NOP_WORD = '0,
  localparam int CW = WW + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] addrDma,
  input  logic [AW-1:0] addrData,
  input  logic [AW-1:0] addrFetch,
  input  logic [WW-1:0] extMemWait,
  input  logic [WW-1:0] extIoWait,
  input  logic [DW-1:0] busRdData,
  output logic          cntZero,
  output logic          ramFetch,
  output logic          suppress,
  output logic [AW-1:0] busAddr,
  output logic [CW-1:0] waitCnt,
  output logic [DW-1:0] rdData
);
  logic [AW-1:0] selAddr;
  region_e       selRegion;
  logic [CW-1:0] selLen;
  region_e       regionQ;
  logic          fetchQ;
  logic [AW-1:0] addrQ;
  logic [CW-1:0] cnt;

  always_comb begin
    if (strb.pick[2])      selAddr = addrDma;
    else if (strb.pick[1]) selAddr = addrData;
    else                   selAddr = addrFetch;
    selRegion = region_e'(selAddr[AW-1 -: 2]);
    case (selRegion)
      RG_XMEM: selLen = CW'(XMEM_MIN) + CW'(extMemWait);
      RG_XIO:  selLen = CW'(XIO_MIN) + CW'(extIoWait);
      default: selLen = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      regionQ <= RG_RAM;
      fetchQ  <= 1'b0;
      cnt     <= '0;
    end else if (strb.load) begin
      addrQ   <= selAddr;
      regionQ <= selRegion;
      fetchQ  <= strb.pick[0];
      cnt     <= selLen - CW'(1);
    end else if (strb.step) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_comb begin
    cntZero  = (cnt == '0);
    ramFetch = fetchQ && (regionQ == RG_RAM);
    suppress = fetchQ && (regionQ == RG_PERI);
    busAddr  = addrQ;
    waitCnt  = cnt;
    rdData   = suppress ? NOP_WORD : busRdData;
  end
endmodule

// File: rtl/bus_cycle_arbiter.sv
module bus_cycle_arbiter
  import bca_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int WW = 3,
  parameter int XMEM_MIN = 2,
  parameter int XIO_MIN = 3,
  parameter logic [DW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqDma,
  input  logic          reqData,
  input  logic          reqFetch,
  input  logic [AW-1:0] addrDma,
  input  logic [AW-1:0] addrData,
  input  logic [AW-1:0] addrFetch,
  input  logic [WW-1:0] extMemWait,
  input  logic [WW-1:0] extIoWait,
  input  logic [DW-1:0] busRdData,
  output logic [2:0]    gnt,
  output logic [AW-1:0] busAddr,
  output logic          busValid,
  output logic [WW+1:0] waitCnt,
  output logic          done,
  output logic [DW-1:0] rdData
);
  strobe_t strb;
  logic    cntZero;
  logic    ramFetch;
  logic    suppress;

  bca_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      ({reqDma, reqData, reqFetch}),
    .cntZero  (cntZero),
    .ramFetch (ramFetch),
    .strb     (strb),
    .gnt      (gnt),
    .done     (done)
  );

  bca_datapath #(
    .AW(AW), .DW(DW), .WW(WW),
    .XMEM_MIN(XMEM_MIN), .XIO_MIN(XIO_MIN), .NOP_WORD(NOP_WORD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addrDma    (addrDma),
    .addrData   (addrData),
    .addrFetch  (addrFetch),
    .extMemWait (extMemWait),
    .extIoWait  (extIoWait),
    .busRdData  (busRdData),
    .cntZero    (cntZero),
    .ramFetch   (ramFetch),
    .suppress   (suppress),
    .busAddr    (busAddr),
    .waitCnt    (waitCnt),
    .rdData     (rdData)
  );

  assign busValid = (|gnt) && !suppress;
endmodule

// File: rtl/bca_checker.sv
module bca_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int WW = 3,
  parameter int XMEM_MIN = 2,
  parameter int XIO_MIN = 3,
  parameter logic [DW-1:0] NOP_WORD = '0
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqDma,
  input logic          reqData,
  input logic          reqFetch,
  input logic [2:0]    gnt,
  input logic [AW-1:0] busAddr,
  input logic          busValid,
  input logic [WW+1:0] waitCnt,
  input logic          done,
  input logic [DW-1:0] rdData
);
  logic [2:0] req;
  logic [2:0] expPick;
  logic [1:0] region;
  logic [7:0] prevRun;
  logic [7:0] runLen;

  assign req    = {reqDma, reqData, reqFetch};
  assign region = busAddr[AW-1 -: 2];

  always_comb begin
    expPick = 3'b000;
    if (req[2])      expPick = 3'b100;
    else if (req[1]) expPick = 3'b010;
    else if (req[0]) expPick = 3'b001;
  end

  assign runLen = (|gnt) ? prevRun + 8'd1 : 8'd0;
  always_ff @(posedge clk) begin
    if (!rstN)     prevRun <= 8'd0;
    else if (done) prevRun <= 8'd0;
    else           prevRun <= runLen;
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));

  // R1
  gnt_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|gnt) && $past(gnt) == 3'b000) |-> gnt == $past(expPick));

  // R2
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|gnt) && !done) |=> gnt == $past(gnt));

  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> gnt == 3'b000);

  // R4
  ram_data_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && region == 2'b00 && !gnt[0]) |-> runLen == 8'd1);

  // R5
  ram_fetch_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && region == 2'b00 && gnt[0]) |-> runLen <= 8'd2);

  // R6
  xmem_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && region == 2'b01) |-> runLen >= 8'(XMEM_MIN));

  // R7
  xio_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && region == 2'b10) |-> runLen >= 8'(XIO_MIN));

  // R8
  peri_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && gnt[0] && region == 2'b11) |-> (!busValid && rdData == NOP_WORD));

  // R9
  wait_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|gnt) && !done && waitCnt != '0) |=> waitCnt == $past(waitCnt) - 1'b1);

  // R10
  done_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (|gnt));
endmodule

bind bus_cycle_arbiter bca_checker #(
  .AW(AW), .DW(DW), .WW(WW),
  .XMEM_MIN(XMEM_MIN), .XIO_MIN(XIO_MIN), .NOP_WORD(NOP_WORD)
) u_chk (
  .clk(clk), .rstN(rstN), .reqDma(reqDma), .reqData(reqData),
  .reqFetch(reqFetch), .gnt(gnt), .busAddr(busAddr), .busValid(busValid),
  .waitCnt(waitCnt), .done(done), .rdData(rdData)
);

// File: tb/test_bus_cycle_arbiter.sv
module test_bus_cycle_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int WW = 3;

  typedef struct packed {
    logic [2:0]    req;
    logic [AW-1:0] aDma;
    logic [AW-1:0] aData;
    logic [AW-1:0] aFetch;
    logic [WW-1:0] memW;
    logic [WW-1:0] ioW;
    logic [2:0]    expGnt;
    logic [7:0]    expLen;
    logic          expValid;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{3'b111, 16'h0010, 16'h4000, 16'h0020, 3'd0, 3'd0, 3'b100, 8'd1,  1'b1},
    '{3'b011, 16'h0000, 16'h4004, 16'h0020, 3'd0, 3'd0, 3'b010, 8'd2,  1'b1},
    '{3'b001, 16'h0000, 16'h0000, 16'h0100, 3'd0, 3'd0, 3'b001, 8'd1,  1'b1},
    '{3'b010, 16'h0000, 16'h8000, 16'h0000, 3'd0, 3'd0, 3'b010, 8'd3,  1'b1},
    '{3'b010, 16'h0000, 16'h8002, 16'h0000, 3'd0, 3'd4, 3'b010, 8'd7,  1'b1},
    '{3'b100, 16'h4000, 16'h0000, 16'h0000, 3'd5, 3'd0, 3'b100, 8'd7,  1'b1},
    '{3'b001, 16'h0000, 16'h0000, 16'hC000, 3'd0, 3'd0, 3'b001, 8'd1,  1'b0},
    '{3'b010, 16'h0000, 16'hC010, 16'h0000, 3'd0, 3'd0, 3'b010, 8'd1,  1'b1},
    '{3'b101, 16'h8000, 16'h0000, 16'h0000, 3'd0, 3'd7, 3'b100, 8'd10, 1'b1},
    '{3'b001, 16'h0000, 16'h0000, 16'h7FFE, 3'd1, 3'd0, 3'b001, 8'd3,  1'b1},
    '{3'b100, 16'hFFFF, 16'h0000, 16'h0000, 3'd0, 3'd0, 3'b100, 8'd1,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqDma = 1'b0, reqData = 1'b0, reqFetch = 1'b0;
  logic [AW-1:0] addrDma = '0, addrData = '0, addrFetch = '0;
  logic [WW-1:0] extMemWait = '0, extIoWait = '0;
  logic [DW-1:0] busRdData;
  logic [2:0]    gnt;
  logic [AW-1:0] busAddr;
  logic          busValid;
  logic [WW+1:0] waitCnt;
  logic          done;
  logic [DW-1:0] rdData;

  int nChecks = 0;
  int nFails = 0;

  assign busRdData = {16'hBEEF, busAddr};

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_arbiter i_bus_cycle_arbiter (
    .clk(clk), .rstN(rstN), .reqDma(reqDma), .reqData(reqData),
    .reqFetch(reqFetch), .addrDma(addrDma), .addrData(addrData),
    .addrFetch(addrFetch), .extMemWait(extMemWait), .extIoWait(extIoWait),
    .busRdData(busRdData), .gnt(gnt), .busAddr(busAddr),
    .busValid(busValid), .waitCnt(waitCnt), .done(done), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  // waits for a grant; returns 0 on timeout
  task automatic waitGrant(output bit got);
    got = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (gnt != 3'b000) begin got = 1'b1; break; end
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    bit got;
    logic [2:0] g0;
    logic [WW+1:0] w0;
    logic [AW-1:0] expAddr;
    logic [DW-1:0] expRd;
    int len;
    bit stable;
    bit validOk;
    @(negedge clk);
    {reqDma, reqData, reqFetch} = v.req;
    addrDma = v.aDma; addrData = v.aData; addrFetch = v.aFetch;
    extMemWait = v.memW; extIoWait = v.ioW;
    expAddr = v.expGnt[2] ? v.aDma : (v.expGnt[1] ? v.aData : v.aFetch);
    expRd = v.expValid ? {16'hBEEF, expAddr} : 32'h0;
    waitGrant(got);
    check(got, $sformatf("R1 vec%0d grant seen", idx), 64'(got), 64'd1);
    g0 = gnt; w0 = waitCnt;
    check(g0 == v.expGnt, $sformatf("R1 vec%0d gnt", idx), 64'(g0), 64'(v.expGnt));
    check(w0 == (WW+2)'(v.expLen - 8'd1), $sformatf("R9 vec%0d waitCnt first", idx),
          64'(w0), 64'(v.expLen - 8'd1));
    check(busAddr == expAddr, $sformatf("R9 vec%0d busAddr", idx), 64'(busAddr), 64'(expAddr));
    len = 1; stable = 1'b1; validOk = 1'b1;
    while (!done && len < 40) begin
      if (busValid != v.expValid) validOk = 1'b0;
      @(negedge clk);
      len++;
      if (gnt != g0) stable = 1'b0;
    end
    if (busValid != v.expValid) validOk = 1'b0;
    check(len == int'(v.expLen), $sformatf("R3 R4 R6 R7 R8 vec%0d length", idx),
          64'(len), 64'(v.expLen));
    check(stable, $sformatf("R2 vec%0d gnt held", idx), 64'(gnt), 64'(g0));
    check(validOk, $sformatf("R8 R9 vec%0d busValid", idx), 64'(busValid), 64'(v.expValid));
    check(rdData == expRd, $sformatf("R8 R9 vec%0d rdData", idx), 64'(rdData), 64'(expRd));
    {reqDma, reqData, reqFetch} = 3'b000;
  endtask

  initial begin
    bit got;
    int len;
    bit stable;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(gnt == 3'b000 && !done && !busValid, "R10 in reset", 64'({gnt, done, busValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(gnt == 3'b000 && !done && !busValid, "R10 after reset", 64'({gnt, done, busValid}), 64'd0);

    for (int i = 0; i < NVEC; i++) runVec(VEC[i], i);

    // R5: fetch from RAM meets a data request in its first clock
    @(negedge clk);
    extMemWait = '0; extIoWait = '0;
    reqFetch = 1'b1; addrFetch = 16'h0010;
    waitGrant(got);
    check(gnt == 3'b001, "R5 fetch granted", 64'(gnt), 64'b001);
    reqData = 1'b1; addrData = 16'h0040;
    #1;
    check(!done, "R5 fetch stretched in first clock", 64'(done), 64'd0);
    @(negedge clk);
    check(done && gnt == 3'b001, "R5 fetch done in second clock", 64'({done, gnt}), 64'b1001);
    check(rdData == {16'hBEEF, 16'h0010}, "R5 fetch rdData", 64'(rdData), 64'hBEEF0010);
    reqFetch = 1'b0;
    @(negedge clk);
    check(gnt == 3'b000, "R2 idle gap after stretched fetch", 64'(gnt), 64'd0);
    @(negedge clk);
    check(gnt == 3'b010 && done, "R4 data served after fetch", 64'({done, gnt}), 64'b1010);
    reqData = 1'b0;

    // R2: no preemption of a long external I/O cycle by DMA
    @(negedge clk);
    extIoWait = 3'd3;
    reqData = 1'b1; addrData = 16'h8000;
    waitGrant(got);
    check(gnt == 3'b010, "R2 data granted", 64'(gnt), 64'b010);
    reqDma = 1'b1; addrDma = 16'h0004;
    len = 1; stable = 1'b1;
    while (!done && len < 40) begin
      @(negedge clk);
      len++;
      if (gnt != 3'b010) stable = 1'b0;
    end
    check(stable, "R2 grant not preempted", 64'(gnt), 64'b010);
    check(len == 6, "R7 io length with 3 waits", 64'(len), 64'd6);
    reqData = 1'b0;
    @(negedge clk);
    check(gnt == 3'b000, "R2 idle clock after done", 64'(gnt), 64'd0);
    @(negedge clk);
    check(gnt == 3'b100 && done, "R1 waiting dma granted next", 64'({done, gnt}), 64'b1100);
    reqDma = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(gnt == 3'b000 && !busValid, "R10 idle with no requests", 64'({gnt, busValid}), 64'd0);

    summary();
  end
endmodule